// File: doc/BRIEF.md
# Timer tick source selector

This block decides when a 16-bit timer advances. It produces a one-cycle `tick` strobe that is synchronous to the system clock. A 3-bit select value picks the source of the strobe. The sources are: the stopped state, every system clock, one of four divided rates, or edges seen on an external pin. The counter that consumes the strobe, and the compare and capture logic around it, live elsewhere.

A 10-bit prescaler counts on every system clock and is shared by all the divided rates. The select value only chooses which prescaler tap drives the strobe. Changing the select therefore never disturbs the prescaler phase. The external pin passes through a two-flop synchronizer and an edge detector, and either its falling or its rising edges become ticks. No direction or output-enable qualifier is applied to the pin path. If the pin is also being driven as an output, software that toggles it can still step the timer.

Top module: `tick_source_sel`

## Requirements
- R1: While `rst` is high, `tick` is low from the first clock edge onward. `rst` also clears the prescaler. After release, count system clock edges from 1, starting with the first edge at which `rst` is low. In a divided mode, the first tick then follows edge 1.
- R2: With `clkSel` = 3'b000 the timer is stopped. `tick` stays low, and changes on `extPin` in either direction have no effect.
- R3: With `clkSel` = 3'b001, `tick` is high after every clock edge at which that code is applied.
- R4: Codes 3'b010, 3'b011, 3'b100 and 3'b101 select periods P of 8, 64, 256 and 1024 clocks. `tick` is high after edge k exactly when (k-1) mod P is 0, with k counted as in R1.
- R5: With `clkSel` = 3'b110, a falling edge on `extPin` produces exactly one tick. Take the first clock edge after the pin changes as edge 1; the tick is high after edge 3 only.
- R6: With `clkSel` = 3'b111, a rising edge on `extPin` produces exactly one tick, with the same three-edge latency as R5.
- R7: A rising edge on `extPin` produces no tick under code 3'b110, and a falling edge produces no tick under code 3'b111.
- R8: While the select is held steady, `tick` is never high for two consecutive cycles, except under code 3'b001.
- R9: A new `clkSel` value takes effect at the next clock edge. It neither resets nor shifts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clkSel | input | 3 | Tick source select code |
| extPin | input | 1 | External pin, asynchronous to `clk` |
| tick | output | 1 | One-cycle count-enable strobe |

## Verification
The divided modes are checked against a phase reference counted from reset release. The select value is switched between modes partway through a run, with no reset in between. A design that restarted the prescaler on a select change, or that compared taps against the wrong bit count, would put ticks at shifted or wrong intervals, and the mismatch counter would catch it. The pin modes are probed cycle by cycle around each edge. This exposes a missing or extra synchronizer stage as a tick that arrives one cycle early or late. It also exposes swapped rising and falling codes as a tick on the wrong edge. The stopped code is held while the pin toggles, which catches a decode that lets the pin path leak through.

// File: rtl/tick_src_pkg.sv
package tick_src_pkg;

  localparam int NUM_TAPS = 4;
  // log2 of each prescaler ratio, in the order of select codes 010..101
  localparam int TAP_LOG [NUM_TAPS] = '{3, 6, 8, 10};
  localparam int PRE_W = TAP_LOG[NUM_TAPS-1];
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STOP     = 3'b000,
    SEL_DIV1     = 3'b001,
    SEL_DIV8     = 3'b010,
    SEL_DIV64    = 3'b011,
    SEL_DIV256   = 3'b100,
    SEL_DIV1024  = 3'b101,
    SEL_PIN_FALL = 3'b110,
    SEL_PIN_RISE = 3'b111
  } clkSel_e;

  typedef struct packed {
    logic [NUM_TAPS-1:0] tap;
    logic                rise;
    logic                fall;
  } srcStrobes_t;

endpackage

// File: rtl/tick_src_datapath.sv
module tick_src_datapath
  import tick_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pinIn,
  output srcStrobes_t strobes
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  // shared free-running prescaler
  logic [PRE_W-1:0] preCnt;
  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + PRE_W'(1);
  end

  logic [NUM_TAPS-1:0] tapHit;
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tapHit[g] = (preCnt[TAP_LOG[g]-1:0] == '0);
  end

  // pin synchronizer and edge detector
  logic [SYNC_MSB:0] syncReg;
  logic              pinPrev;
  logic              pinSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncReg <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncReg <= {syncReg[SYNC_MSB-1:0], pinIn};
      pinPrev <= syncReg[SYNC_MSB];
    end
  end

  assign pinSync = syncReg[SYNC_MSB];

  always_comb begin
    strobes.tap  = tapHit;
    strobes.rise = pinSync & ~pinPrev;
    strobes.fall = ~pinSync & pinPrev;
  end

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.rise |=> !strobes.rise);

  // R5
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.fall |=> !strobes.fall);

  // R4: a coarser tap only fires together with every finer tap
  for (genvar g = 1; g < NUM_TAPS; g++) begin : g_nest
    tap_nest_chk: assert property (@(posedge clk) disable iff (rst)
      tapHit[g] |-> tapHit[g-1]);
  end

endmodule

// File: rtl/tick_src_ctrl.sv
module tick_src_ctrl
  import tick_src_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] selIn,
  input  srcStrobes_t      strobes,
  output logic             tickOut
);

  clkSel_e selMode;
  logic    nextTick;

  assign selMode = clkSel_e'(selIn);

  always_comb begin
    nextTick = 1'b0;
    unique case (selMode)
      SEL_STOP:     nextTick = 1'b0;
      SEL_DIV1:     nextTick = 1'b1;
      SEL_DIV8:     nextTick = strobes.tap[0];
      SEL_DIV64:    nextTick = strobes.tap[1];
      SEL_DIV256:   nextTick = strobes.tap[2];
      SEL_DIV1024:  nextTick = strobes.tap[3];
      SEL_PIN_FALL: nextTick = strobes.fall;
      SEL_PIN_RISE: nextTick = strobes.rise;
      default:      nextTick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tickOut <= 1'b0;
    else     tickOut <= nextTick;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !tickOut);

  // R2
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (selIn == SEL_STOP) |=> !tickOut);

  // R3
  div1_every_chk: assert property (@(posedge clk) disable iff (rst)
    (selIn == SEL_DIV1) |=> tickOut);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tickOut && selIn != SEL_DIV1 && $stable(selIn)) |=> !tickOut);

  // R4
  div8_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (selIn == SEL_DIV8 && strobes.tap[0]) |=> tickOut);

  // R7
  wrong_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (selIn == SEL_PIN_FALL && strobes.rise) |=> !tickOut);

endmodule

// File: rtl/tick_source_sel.sv
module tick_source_sel
  import tick_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clkSel,
  input  logic       extPin,
  output logic       tick
);

  srcStrobes_t strobes;

  tick_src_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .pinIn   (extPin),
    .strobes (strobes)
  );

  tick_src_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .selIn   (clkSel),
    .strobes (strobes),
    .tickOut (tick)
  );

endmodule

// File: tb/tick_source_sel_bench.sv
`timescale 1ns/1ps
module tick_source_sel_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clkSel = 3'b000;
  logic       extPin = 1'b0;
  logic       tick;

  int checks = 0;
  int fails = 0;
  int edgeK = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_source_sel u_tick_source_sel (
    .clk    (clk),
    .rst    (rst),
    .clkSel (clkSel),
    .extPin (extPin),
    .tick   (tick)
  );

  // bench's own edge count since reset release (R1 numbering)
  always @(posedge clk) begin
    if (rst) edgeK <= 0;
    else     edgeK <= edgeK + 1;
  end

  localparam int NVEC = 8;
  localparam int VSEL [NVEC] = '{2, 3, 0, 4, 1, 5, 2, 3};
  localparam int VLEN [NVEC] = '{40, 200, 20, 600, 10, 2100, 17, 150};

  function automatic int periodOf(input int s);
    case (s)
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 1;
    endcase
  endfunction

  function automatic int expTick(input int s, input int k);
    if (s == 0) return 0;
    if (s == 1) return 1;
    return (((k - 1) % periodOf(s)) == 0) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive pin, sample tick after each of the next four edges
  task automatic pinStep(input logic newPin, input int expAt3, input string req);
    int pattern;
    pattern = 0;
    extPin = newPin;
    for (int i = 0; i < 4; i++) begin
      cycle();
      pattern = (pattern << 1) | int'(tick);
    end
    check(req, pattern, expAt3 ? 4'b0010 : 4'b0000);
    for (int i = 0; i < 3; i++) cycle();
  endtask

  task automatic quietWindow(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      cycle();
      seen += int'(tick);
    end
    check(req, seen, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    // R1: reset state
    clkSel = 3'b001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 tick low in reset", int'(tick), 0);

    // table walk: divided, stopped and direct modes, prescaler never reset (R4, R9, R3, R2, R8)
    clkSel = 3'(VSEL[0]);
    rst = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      int bad;
      int firstK;
      int firstAct;
      bad = 0;
      firstK = -1;
      firstAct = 0;
      clkSel = 3'(VSEL[v]);
      for (int c = 0; c < VLEN[v]; c++) begin
        cycle();
        if (int'(tick) != expTick(VSEL[v], edgeK)) begin
          if (bad == 0) begin
            firstK = edgeK;
            firstAct = int'(tick);
          end
          bad++;
        end
      end
      if (bad != 0)
        $display("  vector %0d sel=%0d first mismatch at edge %0d tick=%0d", v, VSEL[v], firstK, firstAct);
      check($sformatf("R4 R9 R8 table vector %0d sel=%0d mismatches", v, VSEL[v]), bad, 0);
    end

    // R1: reset clears the prescaler; first divide-by-8 tick follows edge 1
    rst = 1'b1;
    clkSel = 3'b001;
    cycle();
    check("R1 reset overrides divide-by-1", int'(tick), 0);
    cycle();
    clkSel = 3'b010;
    rst = 1'b0;
    cycle();
    check("R1 first tick after edge 1", int'(tick), 1);
    begin
      int seen;
      seen = 0;
      for (int i = 2; i <= 8; i++) begin
        cycle();
        seen += int'(tick);
      end
      check("R1 no tick on edges 2..8", seen, 0);
      cycle();
      check("R1 tick after edge 9", int'(tick), 1);
    end

    // R3: divide-by-1 applies at the next edge
    clkSel = 3'b001;
    cycle();
    check("R3 tick on first divide-by-1 edge", int'(tick), 1);
    cycle();
    check("R3 tick held in divide-by-1", int'(tick), 1);

    // R2: stopped, pin toggling ignored
    clkSel = 3'b000;
    extPin = 1'b0;
    cycle();
    extPin = 1'b1;
    quietWindow(8, "R2 stop ignores rising pin");
    extPin = 1'b0;
    quietWindow(8, "R2 stop ignores falling pin");

    // R5 / R7: falling-edge mode
    clkSel = 3'b110;
    quietWindow(4, "R5 no tick without pin edge");
    pinStep(1'b1, 0, "R7 rising ignored in falling mode");
    pinStep(1'b0, 1, "R5 falling edge one tick at edge 3");
    pinStep(1'b1, 0, "R7 second rising ignored");
    pinStep(1'b0, 1, "R5 second falling edge ticks");

    // R6 / R7: rising-edge mode
    clkSel = 3'b111;
    quietWindow(4, "R6 no tick on mode switch");
    pinStep(1'b1, 1, "R6 rising edge one tick at edge 3");
    pinStep(1'b0, 0, "R7 falling ignored in rising mode");
    pinStep(1'b1, 1, "R6 second rising edge ticks");
    pinStep(1'b0, 0, "R7 second falling ignored");

    finishRun();
  end

endmodule